// File: doc/BRIEF.md
# Programmable Down-Counting Timer

A single-channel 32-bit countdown timer on an APB slave port. Software writes a start value into the load register and sets the run bit. The counter then decrements once per clock. When it has reached zero it either reloads the start value latched at launch (periodic mode) or wraps to all ones and keeps going (free-running mode). The inverse of the current value gives a rising count, so the same channel serves both as an event source and as a free-running time base.

Each expiry sets a raw pending flag. A mask bit in the control register gates the pending flag onto the interrupt line and into the masked status views without stopping the counter. The flag is cleared by a read, not a write: a read of either the channel acknowledge register or the global acknowledge register clears it. A constant identification word lets drivers confirm what they are talking to.

Top module: `tick_timer`

## Requirements
- R1: Register offsets are load 0x00, current count 0x04, control 0x08, channel acknowledge 0x0C, channel masked status 0x10, global masked status 0xA0, global acknowledge 0xA4, raw status 0xA8 and identification 0xAC. The load and control registers read back what was written. Identification reads the VERSION parameter. Any other offset reads zero. pready_o is always 1 and pslverr_o is always 0.
- R2: Control bit 0 is run. A write that takes run from 0 to 1 loads the counter from the load register on that access edge. While run is 1 the counter decrements by one every clock. While run is 0 it holds its value.
- R3: Control bit 1 selects the mode, 1 for periodic. When run is 1 and the counter holds zero, the next clock reloads it with the value latched at the last launch and sets the raw status (bit 0 of 0xA8).
- R4: With control bit 1 at 0, a counter at zero wraps to 0xFFFFFFFF on the next clock and keeps decrementing.
- R5: Control bit 2 is the mask, 1 to mask. irq_o, 0x10 bit 0 and 0xA0 bit 0 equal raw status AND NOT mask. The raw status and the counter are not affected by the mask.
- R6: A completed read of 0x0C or 0xA4 returns zero and clears the raw status on that access edge. An expiry on the same edge wins.
- R7: A load register write while running changes neither the current count nor the reload value. The new value takes effect only at the next 0-to-1 transition of run.
- R8: Writes to current count, both status registers, raw status and identification are ignored.
- R9: After reset the control, load and counter registers are zero, and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the counter ticks on it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB direction, 1 = write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| irq_o | output | 1 | Masked interrupt |

## Verification
The counter is exercised in three ways: a short periodic reload, a free-running launch from a small value so that the wrap to all ones can be seen, and a periodic run whose load register is rewritten mid-flight. Comparing these separates the reload source (the value latched at launch versus the live register) from the wrap path. Acknowledge reads are issued through both the channel and the global offset while the timer is stopped, so a missed clear cannot be hidden by a fresh expiry. A masked run, followed by unmasking with the flag still pending, shows that masking gates only the output and leaves the counter and the raw flag untouched.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned OFF_LOAD  = 'h00;
  localparam int unsigned OFF_CUR   = 'h04;
  localparam int unsigned OFF_CTRL  = 'h08;
  localparam int unsigned OFF_ACK   = 'h0C;
  localparam int unsigned OFF_STAT  = 'h10;
  localparam int unsigned OFF_GSTAT = 'hA0;
  localparam int unsigned OFF_GACK  = 'hA4;
  localparam int unsigned OFF_RAW   = 'hA8;
  localparam int unsigned OFF_ID    = 'hAC;

  // bit 2 mask, bit 1 periodic, bit 0 run
  typedef struct packed {
    logic mask;
    logic periodic;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CNT_W   = 32,
  parameter logic [31:0] VERSION = 32'h5449_0102
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              raw_i,
  input  logic              pend_i,
  output logic [DATA_W-1:0] prdata_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              start_o,
  output logic              ack_o
);
  logic  access, wr, rd;
  ctrl_t ctrl_q, ctrl_wdata;
  logic [CNT_W-1:0] load_q;

  assign access     = psel_i & penable_i;
  assign wr         = access & pwrite_i;
  assign rd         = access & ~pwrite_i;
  assign ctrl_wdata = ctrl_t'(pwdata_i[2:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else if (wr) begin
      if (paddr_i == ADDR_W'(OFF_CTRL)) ctrl_q <= ctrl_wdata;
      if (paddr_i == ADDR_W'(OFF_LOAD)) load_q <= pwdata_i[CNT_W-1:0];
    end
  end

  assign start_o = wr & (paddr_i == ADDR_W'(OFF_CTRL)) & ctrl_wdata.run & ~ctrl_q.run;
  assign ack_o   = rd & ((paddr_i == ADDR_W'(OFF_ACK)) | (paddr_i == ADDR_W'(OFF_GACK)));
  assign ctrl_o  = ctrl_q;
  assign load_o  = load_q;

  always_comb begin
    prdata_o = '0;
    case (paddr_i)
      ADDR_W'(OFF_LOAD):  prdata_o = DATA_W'(load_q);
      ADDR_W'(OFF_CUR):   prdata_o = DATA_W'(cnt_i);
      ADDR_W'(OFF_CTRL):  prdata_o = DATA_W'(ctrl_q);
      ADDR_W'(OFF_STAT),
      ADDR_W'(OFF_GSTAT): prdata_o = DATA_W'(pend_i);
      ADDR_W'(OFF_RAW):   prdata_o = DATA_W'(raw_i);
      ADDR_W'(OFF_ID):    prdata_o = VERSION;
      default:            prdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             periodic_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] period_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, period_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = run_i & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= '0;
    end else if (start_i) begin
      cnt_q    <= load_i;
      period_q <= load_i; // reload source frozen at launch
    end else if (run_i) begin
      if (at_zero && periodic_i) cnt_q <= period_q;
      else                       cnt_q <= cnt_q - CNT_W'(1); // wraps to all ones
    end
  end

  assign cnt_o    = cnt_q;
  assign period_o = period_q;
endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic ack_i,
  input  logic mask_i,
  output logic raw_o,
  output logic pend_o
);
  logic raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       raw_q <= 1'b0;
    else if (expire_i) raw_q <= 1'b1;
    else if (ack_i)    raw_q <= 1'b0;
  end

  assign raw_o  = raw_q;
  assign pend_o = raw_q & ~mask_i;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CNT_W   = 32,
  parameter logic [31:0] VERSION = 32'h5449_0102
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load, cnt, period;
  logic             start, ack, expire, raw, pend;

  tick_timer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .VERSION(VERSION)) u_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .cnt_i(cnt), .raw_i(raw), .pend_i(pend), .prdata_o,
    .ctrl_o(ctrl_q), .load_o(load), .start_o(start), .ack_o(ack)
  );

  tick_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .run_i(ctrl_q.run), .periodic_i(ctrl_q.periodic),
    .start_i(start), .load_i(load), .cnt_o(cnt), .period_o(period), .expire_o(expire)
  );

  tick_timer_irq u_irq (
    .clk_i, .rst_ni, .expire_i(expire), .ack_i(ack), .mask_i(ctrl_q.mask),
    .raw_o(raw), .pend_o(pend)
  );

  assign irq_o     = pend;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             periodic_i,
  input logic             start_i,
  input logic             ack_i,
  input logic [CNT_W-1:0] load_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] period_i,
  input logic             raw_i
);
  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_i == $past(load_i));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(cnt_i));
  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i != '0) |=> cnt_i == $past(cnt_i) - CNT_W'(1));
  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && periodic_i && cnt_i == '0) |=> cnt_i == $past(period_i));
  assert_raw_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == '0) |=> raw_i);
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !periodic_i && cnt_i == '0) |=> &cnt_i);
  assert_ack_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(run_i && cnt_i == '0)) |=> !raw_i);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl_q.run), .periodic_i(ctrl_q.periodic),
  .start_i(start), .ack_i(ack), .load_i(load), .cnt_i(cnt), .period_i(period), .raw_i(raw)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam logic [31:0] VER = 32'h5449_0102;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pready, pslverr, irq;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  tick_timer #(.ADDR_W(8), .CNT_W(32), .VERSION(VER)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pslverr_o(pslverr), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_load, m_cnt, m_per;
  logic [2:0]  m_ctrl;
  logic        m_raw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_load = 0; m_cnt = 0; m_per = 0; m_ctrl = 0; m_raw = 0;
    end else begin
      bit acc, fire, launch, clr;
      acc    = psel && penable;
      fire   = m_ctrl[0] && (m_cnt == 0);
      launch = acc && pwrite && paddr == 8'h08 && pwdata[0] && !m_ctrl[0];
      clr    = acc && !pwrite && (paddr == 8'h0C || paddr == 8'hA4);
      if (launch) begin m_cnt = m_load; m_per = m_load; end
      else if (m_ctrl[0]) begin
        if (m_cnt != 0) m_cnt = m_cnt - 1;
        else m_cnt = m_ctrl[1] ? m_per : 32'hFFFF_FFFF;
      end
      m_raw = fire || (m_raw && !clr);
      if (acc && pwrite && paddr == 8'h00) m_load = pwdata;
      if (acc && pwrite && paddr == 8'h08) m_ctrl = pwdata[2:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_load;
      8'h04: return m_cnt;
      8'h08: return {29'd0, m_ctrl};
      8'h10, 8'hA0: return {31'd0, m_raw && !m_ctrl[2]};
      8'hA8: return {31'd0, m_raw};
      8'hAC: return VER;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5 irq", {31'd0, irq}, {31'd0, m_raw && !m_ctrl[2]});
      if (psel && penable) begin
        chk("R1 pready", {31'd0, pready}, 32'd1);
        chk("R1 pslverr", {31'd0, pslverr}, 32'd0);
        if (!pwrite) chk("R1 read", prdata, m_read(paddr));
      end
    end
  end

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk); #2;
      if (irq) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    idle(3); rst_n = 1; idle(2);
    // R9 reset state
    apb_rd(8'h08, d); chk("R9 ctrl", d, 0);
    apb_rd(8'h00, d); chk("R9 load", d, 0);
    apb_rd(8'h04, d); chk("R9 count", d, 0);
    apb_rd(8'hA8, d); chk("R9 raw", d, 0);
    chk("R9 irq", {31'd0, irq}, 0);
    // R1 map
    apb_wr(8'h00, 32'd5);
    apb_rd(8'h00, d); chk("R1 load rb", d, 5);
    apb_rd(8'hAC, d); chk("R1 id", d, VER);
    apb_rd(8'h14, d); chk("R1 unmapped", d, 0);
    apb_rd(8'hB0, d); chk("R1 unmapped hi", d, 0);
    // R8 read-only writes
    apb_wr(8'h04, 32'h1234); apb_wr(8'hAC, 32'h0); apb_wr(8'hA8, 32'h1);
    apb_rd(8'h04, d); chk("R8 count", d, 0);
    apb_rd(8'hAC, d); chk("R8 id", d, VER);
    apb_rd(8'hA8, d); chk("R8 raw", d, 0);
    // R2/R3 periodic launch
    apb_wr(8'h08, 32'h2); apb_wr(8'h08, 32'h3);
    apb_rd(8'h08, d); chk("R1 ctrl rb", d, 3);
    wait_irq(50); chk("R3 irq", {31'd0, irq}, 1);
    apb_wr(8'h08, 32'h2);
    apb_rd(8'hA8, d); chk("R3 raw", d, 1);
    apb_rd(8'h10, d); chk("R5 stat", d, 1);
    apb_rd(8'hA0, d); chk("R5 gstat", d, 1);
    apb_rd(8'h04, d); apb_rd(8'h04, d2); chk("R2 hold", d2, d);
    // R6 channel and global acknowledge
    apb_rd(8'h0C, d); chk("R6 ack data", d, 0);
    chk("R6 irq low", {31'd0, irq}, 0);
    apb_rd(8'hA8, d); chk("R6 raw clr", d, 0);
    apb_wr(8'h08, 32'h3); wait_irq(50); apb_wr(8'h08, 32'h2);
    apb_rd(8'hA4, d); chk("R6 gack data", d, 0);
    apb_rd(8'hA8, d); chk("R6 graw clr", d, 0);
    // R5 masked run
    apb_wr(8'h08, 32'h6); apb_wr(8'h08, 32'h7); idle(20);
    chk("R5 masked irq", {31'd0, irq}, 0);
    apb_rd(8'hA8, d); chk("R5 raw masked", d, 1);
    apb_rd(8'h10, d); chk("R5 stat masked", d, 0);
    apb_rd(8'h04, d); apb_rd(8'h04, d2); chk("R5 counting", {31'd0, d != d2}, 1);
    apb_wr(8'h08, 32'h3); #2 chk("R5 unmask", {31'd0, irq}, 1);
    // R7 load rewrite while running
    apb_wr(8'h00, 32'd100); idle(20);
    apb_rd(8'h04, d); chk("R7 old period", {31'd0, d <= 5}, 1);
    apb_wr(8'h08, 32'h2); apb_wr(8'h08, 32'h3);
    apb_rd(8'h04, d); chk("R7 new period", {31'd0, d > 5 && d <= 100}, 1);
    // R4 free-running wrap
    apb_wr(8'h08, 32'h0); apb_wr(8'h00, 32'd3); apb_wr(8'h08, 32'h1); idle(8);
    apb_rd(8'h04, d); chk("R4 wrap", {8'd0, d[31:8]}, 32'h00FF_FFFF);
    apb_rd(8'hA4, d); idle(5);
    apb_rd(8'hA8, d); chk("R4 no second expiry", d, 0);
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule